// File: doc/BRIEF.md
# Multi-Code Serial Line Encoder

This block turns a stream of data bits into a line waveform under one of five selectable line codes: plain level (NRZ), transition-on-one (NRZI), return-to-zero (RZ), Manchester, and bipolar return-to-zero. Time on the line is divided into bit cells. Each cell spans exactly two half-cell ticks, which come from an enable input. This lets the block produce waveforms that change in the middle of a cell.

At the first tick of a cell the block samples the data bit, its valid flag and the code selection. At the second tick it finishes the cell from what it sampled. Inputs seen at any other time have no effect. Two pieces of state belong to particular codes: the running line level for NRZI, and the mark polarity for bipolar RZ. Both return to their reset values when a cell starts under a code that differs from the previous cell's code. The unipolar codes drive a one-bit line. The bipolar code drives a signed two-bit level, and the one-bit line stays low while it is selected.

Top module: `lnenc_top`

## Requirements
- R1: After reset, line_o is 0 and bip_o is 2'b00; the NRZI level starts at 0 and the bipolar polarity starts at +1.
- R2: Code 0 (NRZ): a valid bit drives line_o to the bit value for both halves of its cell.
- R3: Code 1 (NRZI): a valid 1 inverts the line level kept from the previous cell and a valid 0 keeps it; that level is driven for the whole cell.
- R4: Code 2 (RZ): a valid 1 drives line_o high in the first half and low in the second half; a valid 0 drives it low for both halves.
- R5: Code 3 (Manchester): a valid 1 is high then low, and a valid 0 is low then high, so the line always changes at mid-cell.
- R6: Code 4 (bipolar RZ): a valid 1 drives bip_o to the current polarity (+1 = 2'b01, -1 = 2'b11) in the first half and 2'b00 in the second half, and flips the polarity; a valid 0 gives 2'b00 for the whole cell; line_o stays 0 and 2'b10 never appears.
- R7: A cell sampled with bit_valid_i low drives 0 on both outputs for both halves and leaves the NRZI level and the bipolar polarity unchanged.
- R8: A cell that starts with a code different from the previous cell's code first resets the NRZI level to 0 and the polarity to +1.
- R9: Outputs change only on a clock edge where tick_i is high, and they take the new half-cell value at that same edge.
- R10: Changes to data_i, bit_valid_i and code_sel_i at a cell's second tick or between ticks do not alter that cell's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Half-cell enable; two ticks make one bit cell |
| code_sel_i | input | 3 | Line code: 0 NRZ, 1 NRZI, 2 RZ, 3 Manchester, 4 bipolar RZ |
| bit_valid_i | input | 1 | Data bit present for the cell that starts at this tick |
| data_i | input | 1 | Data bit |
| line_o | output | 1 | Unipolar line level |
| bip_o | output | 2 | Bipolar level: 2'b01 = +1, 2'b00 = 0, 2'b11 = -1 |

## Verification
Each half-cell value becomes visible at the same rising edge that samples its tick. The scoreboard therefore pops one expected item for every tick and compares it at the following falling edge. On falling edges that follow an edge with no tick, the bench checks that both outputs still hold the last value. At each second tick the driver inverts the data and valid inputs and changes the code, so any late sampling shows up in the pop for that half. After the second half of a valid cell, the bench also decodes the two halves it observed and compares the result with the bit it sent.

// File: rtl/lnenc_pkg.sv
package lnenc_pkg;
    localparam int CODE_W = 3;
    localparam int BIP_W  = 2;

    typedef enum logic [CODE_W-1:0] {
        CODE_NRZ  = 3'd0,
        CODE_NRZI = 3'd1,
        CODE_RZ   = 3'd2,
        CODE_MAN  = 3'd3,
        CODE_BIP  = 3'd4
    } code_e;

    localparam logic [BIP_W-1:0] BIP_ZERO = 2'b00;
    localparam logic [BIP_W-1:0] BIP_POS  = 2'b01;
    localparam logic [BIP_W-1:0] BIP_NEG  = 2'b11;
endpackage

// File: rtl/lnenc_cell.sv
module lnenc_cell
    import lnenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick_i,
    input  code_e code_i,
    input  logic  valid_i,
    input  logic  dat_i,
    output logic  start_o,
    output logic  mid_o,
    output logic  chg_o,
    output code_e code_o,
    output logic  valid_o,
    output logic  dat_o
);
    typedef struct packed {
        logic  phase;
        code_e code;
        logic  valid;
        logic  dat;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (tick_i) begin
            cell_d.phase = ~cell_q.phase;
            if (!cell_q.phase) begin
                cell_d.code  = code_i;
                cell_d.valid = valid_i;
                cell_d.dat   = dat_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '{phase: 1'b0, code: CODE_NRZ, valid: 1'b0, dat: 1'b0};
        end else begin
            cell_q <= cell_d;
        end
    end

    assign start_o = tick_i & ~cell_q.phase;
    assign mid_o   = tick_i &  cell_q.phase;
    assign chg_o   = (code_i != cell_q.code);
    assign code_o  = cell_q.code;
    assign valid_o = cell_q.valid;
    assign dat_o   = cell_q.dat;

    // R10: the captured cell contents stay fixed through the second tick
    assert_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mid_o |=> (code_o == $past(code_o)) && (dat_o == $past(dat_o)) && (valid_o == $past(valid_o)));
endmodule

// File: rtl/lnenc_state.sv
module lnenc_state
    import lnenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    input  logic  chg_i,
    input  code_e code_i,
    input  logic  valid_i,
    input  logic  dat_i,
    output logic  lvl_new_o,
    output logic  lvl_o,
    output logic  pos_now_o
);
    typedef struct packed {
        logic lvl;
        logic pos;
    } st_t;

    st_t  st_d, st_q;
    logic eff_lvl, eff_pos;

    always_comb begin
        eff_lvl = chg_i ? 1'b0 : st_q.lvl;
        eff_pos = chg_i ? 1'b1 : st_q.pos;
        st_d    = st_q;
        if (start_i) begin
            st_d.lvl = eff_lvl;
            st_d.pos = eff_pos;
            if (valid_i && dat_i) begin
                case (code_i)
                    CODE_NRZI: st_d.lvl = ~eff_lvl;
                    CODE_BIP:  st_d.pos = ~eff_pos;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lvl: 1'b0, pos: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_new_o = st_d.lvl;
    assign lvl_o     = st_q.lvl;
    assign pos_now_o = eff_pos;

    // R7: an idle cell under an unchanged code leaves both pieces of state alone
    assert_idle_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !valid_i && !chg_i) |=> (st_q == $past(st_q)));
endmodule

// File: rtl/lnenc_wave.sv
module lnenc_wave
    import lnenc_pkg::*;
(
    input  logic             half_i,
    input  code_e            code_i,
    input  logic             valid_i,
    input  logic             dat_i,
    input  logic             lvl_i,
    input  logic             pos_i,
    output logic             line_o,
    output logic [BIP_W-1:0] bip_o
);
    always_comb begin
        line_o = 1'b0;
        bip_o  = BIP_ZERO;
        if (valid_i) begin
            case (code_i)
                CODE_NRZ:  line_o = dat_i;
                CODE_NRZI: line_o = lvl_i;
                CODE_RZ:   line_o = dat_i & ~half_i;
                CODE_MAN:  line_o = half_i ? ~dat_i : dat_i;
                CODE_BIP: begin
                    if (dat_i && !half_i) bip_o = pos_i ? BIP_POS : BIP_NEG;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lnenc_top.sv
module lnenc_top
    import lnenc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] code_sel_i,
    input  logic              bit_valid_i,
    input  logic              data_i,
    output logic              line_o,
    output logic [BIP_W-1:0]  bip_o
);
    typedef struct packed {
        logic             line;
        logic [BIP_W-1:0] bip;
    } out_t;

    code_e            code_in, code_q, w_code;
    logic             start, mid, chg, valid_q, dat_q;
    logic             lvl_new, lvl_q, pos_now;
    logic             w_valid, w_dat, w_lvl;
    logic             w_line;
    logic [BIP_W-1:0] w_bip;
    out_t             out_d, out_q;

    assign code_in = code_e'(code_sel_i);

    lnenc_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .code_i  (code_in),
        .valid_i (bit_valid_i),
        .dat_i   (data_i),
        .start_o (start),
        .mid_o   (mid),
        .chg_o   (chg),
        .code_o  (code_q),
        .valid_o (valid_q),
        .dat_o   (dat_q)
    );

    lnenc_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .chg_i     (chg),
        .code_i    (code_in),
        .valid_i   (bit_valid_i),
        .dat_i     (data_i),
        .lvl_new_o (lvl_new),
        .lvl_o     (lvl_q),
        .pos_now_o (pos_now)
    );

    // first half takes live inputs, second half the captured cell
    assign w_code  = mid ? code_q  : code_in;
    assign w_valid = mid ? valid_q : bit_valid_i;
    assign w_dat   = mid ? dat_q   : data_i;
    assign w_lvl   = mid ? lvl_q   : lvl_new;

    lnenc_wave u_wave (
        .half_i  (mid),
        .code_i  (w_code),
        .valid_i (w_valid),
        .dat_i   (w_dat),
        .lvl_i   (w_lvl),
        .pos_i   (pos_now),
        .line_o  (w_line),
        .bip_o   (w_bip)
    );

    always_comb begin
        out_d = out_q;
        if (tick_i) begin
            out_d.line = w_line;
            out_d.bip  = w_bip;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{line: 1'b0, bip: BIP_ZERO};
        end else begin
            out_q <= out_d;
        end
    end

    assign line_o = out_q.line;
    assign bip_o  = out_q.bip;

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(line_o) && $stable(bip_o)));

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !bit_valid_i) |=> (!line_o && (bip_o == BIP_ZERO)));

    assert_nrz_flat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mid && code_q == CODE_NRZ) |=> $stable(line_o));

    assert_rz_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mid && code_q == CODE_RZ) |=> !line_o);

    assert_man_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mid && code_q == CODE_MAN && valid_q) |=> (line_o != $past(line_o)));

    assert_bip_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bip_o != 2'b10) && ((bip_o == BIP_ZERO) || !line_o));
endmodule

// File: tb/lnenc_top_tb.sv
`timescale 1ns/1ps
module lnenc_top_tb;
    import lnenc_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [CODE_W-1:0] code = '0;
    logic              vld = 1'b0;
    logic              dat = 1'b0;
    logic              line;
    logic [BIP_W-1:0]  bip;

    always #4 clk = ~clk;

    lnenc_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .code_sel_i  (code),
        .bit_valid_i (vld),
        .data_i      (dat),
        .line_o      (line),
        .bip_o       (bip)
    );

    int          n_chk = 0;
    int          n_fail = 0;
    logic [2:0]  exp_q[$];
    string       tag_q[$];
    int          dec_q[$];
    logic        m_lvl = 1'b0;
    logic        m_pos = 1'b1;
    logic [2:0]  m_code = 3'd0;
    logic        pend = 1'b0;
    logic [2:0]  last_obs = 3'd0;
    logic        first_line = 1'b0;
    logic [1:0]  first_bip = 2'b00;

    task automatic chk(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) pend <= tick;

    // monitor: one expected item per tick, hold check otherwise
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected tick", {line, bip}, 3'b000);
                end else begin
                    logic [2:0] e;
                    string      t;
                    int         d;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    d = dec_q.pop_front();
                    chk({line, bip} == e, t, {line, bip}, e);
                    if (d == -2) begin
                        first_line = line;
                        first_bip  = bip;
                    end else if (d >= 0) begin
                        logic dbit;
                        case (d / 2)
                            0:       dbit = line;
                            2:       dbit = first_line;
                            3:       dbit = first_line & ~line;
                            default: dbit = (first_bip != 2'b00);
                        endcase
                        chk(dbit == d[0], {t, " decode"}, {2'b00, dbit}, {2'b00, d[0]});
                    end
                end
            end else begin
                chk({line, bip} == last_obs, "R9 hold", {line, bip}, last_obs);
            end
            last_obs = {line, bip};
        end
    end

    // driver: compute expected halves from the requirements, then tick twice
    task automatic send(input logic [2:0] c, input logic v, input logic b, input int gap);
        logic [2:0] h1;
        logic [2:0] h2;
        logic       chg;
        string      tg;
        chg = (c != m_code);
        if (chg) begin
            m_lvl = 1'b0;
            m_pos = 1'b1;
        end
        m_code = c;
        h1 = 3'b000;
        h2 = 3'b000;
        tg = "R7";
        if (v) begin
            case (c)
                3'd0: begin h1 = {b, 2'b00}; h2 = h1; tg = "R2"; end
                3'd1: begin
                    if (b) m_lvl = ~m_lvl;
                    h1 = {m_lvl, 2'b00}; h2 = h1; tg = "R3";
                end
                3'd2: begin h1 = {b, 2'b00}; tg = "R4"; end
                3'd3: begin h1 = {b, 2'b00}; h2 = {~b, 2'b00}; tg = "R5"; end
                default: begin
                    if (b) begin
                        h1 = {1'b0, (m_pos ? 2'b01 : 2'b11)};
                        m_pos = ~m_pos;
                    end
                    tg = "R6";
                end
            endcase
            if (chg && (c == 3'd1 || c == 3'd4)) tg = {tg, " R8"};
        end
        exp_q.push_back(h1); tag_q.push_back(tg); dec_q.push_back(-2);
        exp_q.push_back(h2); tag_q.push_back({tg, " R10"});
        dec_q.push_back((v && c != 3'd1) ? int'(c) * 2 + int'(b) : -1);
        code = c; vld = v; dat = b; tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        repeat (gap) @(negedge clk);
        code = c + 3'd1; vld = ~v; dat = ~b; tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        vld = v; dat = b;
        repeat (gap) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({line, bip} == 3'b000, "R1 reset outputs", {line, bip}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 NRZ
        send(3'd0, 1, 1, 0); send(3'd0, 1, 0, 1); send(3'd0, 1, 1, 2); send(3'd0, 1, 1, 0); send(3'd0, 1, 0, 0);
        // R3 NRZI with an idle cell in the middle (R7 keeps the level)
        send(3'd1, 1, 1, 1); send(3'd1, 1, 1, 0); send(3'd1, 1, 0, 1); send(3'd1, 1, 1, 0);
        send(3'd1, 0, 1, 1); send(3'd1, 1, 0, 0); send(3'd1, 1, 1, 2); send(3'd1, 1, 1, 0);
        // R4 RZ
        send(3'd2, 1, 1, 0); send(3'd2, 1, 0, 1); send(3'd2, 1, 1, 1);
        // R5 Manchester, then back to NRZI (R8 level reset)
        send(3'd3, 1, 0, 0); send(3'd3, 1, 1, 1); send(3'd3, 1, 1, 0); send(3'd3, 0, 0, 0); send(3'd3, 1, 0, 2);
        send(3'd1, 1, 1, 0); send(3'd1, 1, 0, 0);
        // R6 bipolar with idle cells (R7) and a detour through NRZ (R8 polarity reset)
        send(3'd4, 1, 1, 0); send(3'd4, 1, 0, 1); send(3'd4, 1, 1, 0); send(3'd4, 0, 1, 0);
        send(3'd4, 1, 1, 1); send(3'd4, 1, 1, 0);
        send(3'd0, 1, 1, 0);
        send(3'd4, 1, 1, 0); send(3'd4, 1, 1, 1); send(3'd4, 1, 0, 0); send(3'd4, 1, 1, 0);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all ticks seen", 3'(exp_q.size()), 3'd0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        finish_run();
    end
endmodule